// File: doc/BRIEF.md
# Dual-Channel DAC Sine Test Driver

This block plays back a slow test sine from an eight-entry table and drives both channels of a parallel 8-bit dual DAC. Channel A shows the raw table sine. Channel B shows whatever an external interpolating filter hands back. The block feeds that filter one signed sample per sample period, together with a one-clock input-valid strobe. It also pulses an output-ready strobe at evenly spaced points so that the filter delivers four results per input sample.

Table codes are offset binary (0 to 255, mid-scale 128). The filter works in two's complement, so the block subtracts 128 on the way in and adds 128 on the way back. The analog output voltage falls as the DAC input code rises. For that reason both channel codes are inverted (255 minus the code) before they leave the block. Both DAC channel clocks and write lines follow the inverted system clock, which puts the data edge half a period ahead of the DAC's latch edge. The mode and sleep lines are tied low.

Top module: `dac_sine_driver`

## Requirements
- R1: Channel A data shows 255 minus the current table code. The table is played in index order 0..7 with codes 128, 218, 255, 218, 128, 38, 1, 38, and wraps from index 7 back to 0.
- R2: Each table index is held for SAMPLE_DIV clocks (default 100), so one full sine period is 8*SAMPLE_DIV clocks. The channel A and filter-input outputs change one clock after the index steps.
- R3: Filter input data is the current table code minus 128 as two's complement. It is high for exactly one clock in each sample period: the last clock of the period (clock 99 of 0..99 counted from reset). While it is high, the filter input data holds the code of the index that is ending.
- R4: Filter output-ready is high for exactly one clock every READY_DIV = SAMPLE_DIV/4 clocks (default 25), on clock 24 of each 0..24 count from reset.
- R5: The input-valid and output-ready strobes fall in the same clock once in every sample period, and input-valid is never high without output-ready.
- R6: Channel B data is registered one clock after the filter output is sampled, with the value 255 minus (filter output + 128). The filter output is read as two's complement.
- R7: Each DAC channel clock and each write line equals the inverse of the system clock.
- R8: The DAC mode and sleep lines are held at 0.
- R9: Synchronous active-high reset clears both counters and the table index. It also sets both channel data outputs to 127, sets the filter input data to 0 and holds both strobes low. After release, the sequence restarts from index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (50 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| filt_dout | input | 8 | Two's-complement sample returned by the interpolating filter |
| filt_din | output | 8 | Two's-complement sample sent to the filter |
| filt_in_vld | output | 1 | One-clock strobe marking a new filter input sample |
| filt_out_rdy | output | 1 | One-clock strobe requesting a filter output sample |
| dac_a_data | output | 8 | Inverted code for DAC channel A |
| dac_a_clk | output | 1 | DAC channel A clock |
| dac_a_wr | output | 1 | DAC channel A write line |
| dac_b_data | output | 8 | Inverted code for DAC channel B |
| dac_b_clk | output | 1 | DAC channel B clock |
| dac_b_wr | output | 1 | DAC channel B write line |
| dac_mode | output | 1 | DAC mode select, held low |
| dac_sleep | output | 1 | DAC sleep control, held low |

## Verification
The input-valid strobe and the output-ready strobe come from two separate counters. Because the sample divider is four times the ready divider, they must land in the same clock at the end of every sample period. In that same clock the table index steps and the filter input data must still show the old code. The bench runs the block from a clean reset across more than one sine period. It predicts both strobes from its own clock count and checks each cycle that they coincide at count 99 and that the channel A and filter input values change only on the following clock. A reset applied in the middle of a period must bring both counters back into step, and this is judged by the first coincidence landing again at count 99.

// File: rtl/sine_drv_pkg.sv
`timescale 1ns/1ps
package sine_drv_pkg;
  localparam int unsigned SMP_W  = 8;
  localparam int unsigned TBL_AW = 3;
  localparam int unsigned TBL_N  = 1 << TBL_AW;

  typedef logic [SMP_W-1:0]  smp_t;
  typedef logic [TBL_AW-1:0] tidx_t;

  localparam smp_t MID_CODE  = smp_t'(1 << (SMP_W - 1));
  localparam smp_t FULL_CODE = '1;

  // one sine period, offset binary, 2*pi/8 steps, amplitude 127 around 128
  function automatic smp_t sine_code(input tidx_t idx);
    smp_t v;
    case (idx)
      3'd0: v = 8'd128;
      3'd1: v = 8'd218;
      3'd2: v = 8'd255;
      3'd3: v = 8'd218;
      3'd4: v = 8'd128;
      3'd5: v = 8'd38;
      3'd6: v = 8'd1;
      default: v = 8'd38;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/pace_counter.sv
`timescale 1ns/1ps
module pace_counter #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst,
  output logic last_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == LAST);
endmodule

// File: rtl/sine_table_rom.sv
`timescale 1ns/1ps
module sine_table_rom
  import sine_drv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step_i,
  output smp_t code_o
);
  tidx_t idx_q;

  always_ff @(posedge clk) begin
    if (rst)         idx_q <= '0;
    else if (step_i) idx_q <= idx_q + 1'b1;
  end

  assign code_o = sine_code(idx_q);
endmodule

// File: rtl/dac_code_reg.sv
`timescale 1ns/1ps
module dac_code_reg
  import sine_drv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  smp_t code_i,
  output smp_t dac_o
);
  always_ff @(posedge clk) begin
    if (rst) dac_o <= FULL_CODE - MID_CODE;
    else     dac_o <= FULL_CODE - code_i;
  end
endmodule

// File: rtl/dac_sine_driver.sv
`timescale 1ns/1ps
module dac_sine_driver
  import sine_drv_pkg::*;
#(
  parameter int unsigned SAMPLE_DIV = 100,
  parameter int unsigned INTERP     = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] filt_dout,
  output logic [7:0] filt_din,
  output logic       filt_in_vld,
  output logic       filt_out_rdy,
  output logic [7:0] dac_a_data,
  output logic       dac_a_clk,
  output logic       dac_a_wr,
  output logic [7:0] dac_b_data,
  output logic       dac_b_clk,
  output logic       dac_b_wr,
  output logic       dac_mode,
  output logic       dac_sleep
);
  localparam int unsigned READY_DIV = SAMPLE_DIV / INTERP;

  logic smp_last;
  logic rdy_last;
  smp_t tbl_code;
  smp_t chb_code;
  smp_t din_q;

  pace_counter #(.DIV(SAMPLE_DIV)) u_smp_cnt (
    .clk(clk), .rst(rst), .last_o(smp_last)
  );

  pace_counter #(.DIV(READY_DIV)) u_rdy_cnt (
    .clk(clk), .rst(rst), .last_o(rdy_last)
  );

  sine_table_rom u_rom (
    .clk(clk), .rst(rst), .step_i(smp_last), .code_o(tbl_code)
  );

  // offset binary to two's complement for the filter
  always_ff @(posedge clk) begin
    if (rst) din_q <= '0;
    else     din_q <= tbl_code - MID_CODE;
  end

  // two's complement back to offset binary for channel B
  assign chb_code = smp_t'(filt_dout) + MID_CODE;

  dac_code_reg u_cha (
    .clk(clk), .rst(rst), .code_i(tbl_code), .dac_o(dac_a_data)
  );

  dac_code_reg u_chb (
    .clk(clk), .rst(rst), .code_i(chb_code), .dac_o(dac_b_data)
  );

  assign filt_din     = din_q;
  assign filt_in_vld  = smp_last;
  assign filt_out_rdy = rdy_last;

  assign dac_a_clk = ~clk;
  assign dac_a_wr  = ~clk;
  assign dac_b_clk = ~clk;
  assign dac_b_wr  = ~clk;
  assign dac_mode  = 1'b0;
  assign dac_sleep = 1'b0;
endmodule

// File: rtl/sine_drv_chk.sv
`timescale 1ns/1ps
module sine_drv_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] filt_dout,
  input logic       filt_in_vld,
  input logic       filt_out_rdy,
  input logic [7:0] dac_a_data,
  input logic [7:0] dac_b_data
);
  // R3
  vld_single_chk: assert property (@(posedge clk) disable iff (rst)
    filt_in_vld |=> !filt_in_vld);

  // R5
  strobe_align_chk: assert property (@(posedge clk) disable iff (rst)
    filt_in_vld |-> filt_out_rdy);

  // R2
  cha_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(filt_in_vld, 2) |-> $stable(dac_a_data));

  // R6
  chb_map_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dac_b_data == 8'(8'd255 - 8'($past(filt_dout) + 8'd128))));

  // R9
  rst_val_chk: assert property (@(posedge clk)
    rst |=> (dac_a_data == 8'd127 && dac_b_data == 8'd127 && !filt_in_vld));
endmodule

bind dac_sine_driver sine_drv_chk u_sine_drv_chk (
  .clk(clk), .rst(rst), .filt_dout(filt_dout),
  .filt_in_vld(filt_in_vld), .filt_out_rdy(filt_out_rdy),
  .dac_a_data(dac_a_data), .dac_b_data(dac_b_data)
);

// File: tb/test_dac_sine_driver.sv
`timescale 1ns/1ps
module test_dac_sine_driver;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] filt_dout = 8'd0;
  logic [7:0] filt_din, dac_a_data, dac_b_data;
  logic       filt_in_vld, filt_out_rdy;
  logic       dac_a_clk, dac_a_wr, dac_b_clk, dac_b_wr, dac_mode, dac_sleep;

  int n_chk = 0;
  int n_bad = 0;
  int n = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  dac_sine_driver i_dac_sine_driver (
    .clk(clk), .rst(rst), .filt_dout(filt_dout), .filt_din(filt_din),
    .filt_in_vld(filt_in_vld), .filt_out_rdy(filt_out_rdy),
    .dac_a_data(dac_a_data), .dac_a_clk(dac_a_clk), .dac_a_wr(dac_a_wr),
    .dac_b_data(dac_b_data), .dac_b_clk(dac_b_clk), .dac_b_wr(dac_b_wr),
    .dac_mode(dac_mode), .dac_sleep(dac_sleep)
  );

  function automatic int tbl(input int k);
    case (k)
      0: return 128; 1: return 218; 2: return 255; 3: return 218;
      4: return 128; 5: return 38;  6: return 1;   default: return 38;
    endcase
  endfunction

  function automatic int exp_code(input int cyc);
    return tbl(((cyc - 1) / 100) % 8);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at n=%0d: actual %0d expected %0d", req, n, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_model(input bit strobes);
    if (n == 0) begin
      chk("R9 dac_a", int'(dac_a_data), 127);
      chk("R9 filt_din", int'(filt_din), 0);
    end else begin
      chk("R1 dac_a", int'(dac_a_data), 255 - exp_code(n));
      chk("R3 filt_din", int'(filt_din), (exp_code(n) + 128) % 256);
    end
    if (strobes) begin
      chk("R3 vld", int'(filt_in_vld), int'(n % 100 == 99));
      chk("R4 rdy", int'(filt_out_rdy), int'(n % 25 == 24));
      if (n % 100 == 99) chk("R5 coincide", int'(filt_in_vld & filt_out_rdy), 1);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) step();
    chk("R9 dac_a", int'(dac_a_data), 127);
    chk("R9 dac_b", int'(dac_b_data), 127);
    chk("R9 filt_din", int'(filt_din), 0);
    chk("R9 vld", int'(filt_in_vld), 0);
    chk("R9 rdy", int'(filt_out_rdy), 0);
    rst = 1'b0;
  endtask

  task automatic t_playback();
    for (int i = 0; i < 850; i++) begin
      step();
      check_model(1'b0);
    end
  endtask

  task automatic t_strobes();
    for (int i = 0; i < 300; i++) begin
      step();
      check_model(1'b1);
    end
  endtask

  task automatic t_chan_b();
    int vals[6] = '{-128, -1, 0, 1, 127, -64};
    foreach (vals[i]) begin
      filt_dout = 8'(vals[i]);
      step();
      chk("R6 dac_b", int'(dac_b_data), 255 - (vals[i] + 128));
    end
  endtask

  task automatic t_dac_lines();
    chk("R7 clk_a low phase", int'(dac_a_clk), 1);
    chk("R7 wr_a low phase", int'(dac_a_wr), 1);
    chk("R7 clk_b low phase", int'(dac_b_clk), 1);
    chk("R7 wr_b low phase", int'(dac_b_wr), 1);
    @(posedge clk);
    #2;
    chk("R7 clk_a high phase", int'(dac_a_clk), 0);
    chk("R7 wr_b high phase", int'(dac_b_wr), 0);
    @(negedge clk);
    chk("R8 mode", int'(dac_mode), 0);
    chk("R8 sleep", int'(dac_sleep), 0);
  endtask

  task automatic t_mid_reset();
    while (n % 100 != 50) step();
    rst = 1'b1;
    step();
    chk("R9 mid dac_a", int'(dac_a_data), 127);
    chk("R9 mid dac_b", int'(dac_b_data), 127);
    chk("R9 mid vld", int'(filt_in_vld), 0);
    rst = 1'b0;
    for (int i = 0; i < 210; i++) begin
      step();
      check_model(1'b1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_playback();
    t_strobes();
    t_chan_b();
    t_dac_lines();
    t_mid_reset();
    finish_run();
  end
endmodule